// File: doc/BRIEF.md
# Bi-phase infrared remote-control frame transmitter

This block turns a one-shot request into a complete infrared remote-control frame. A request carries a variant select and a scancode. Three variants are supported: a 14-bit frame, a 15-bit frame and an extended 20-bit frame. The block first repacks the scancode into the raw bits of the frame. It then sends them bi-phase (Manchester) coded on a time base of one half-bit "unit" (nominally 889 us). Marks are chopped by a 36 kHz carrier. The frame always ends with a long quiet period.

The start bit is never taken from the data. A single leading unit of mark stands for it, and the raw bits follow highest bit first. The extended variant pauses for four units of silence after its eighth bit. A busy flag covers the whole frame, trailer included, and requests made while it is high are dropped. The variant code that names no variant produces a one-cycle error pulse and no frame. Unit length and carrier period are derived from the clock frequency parameter.

Top module: `rc5tx_top`

## Requirements
- R1: With variant code 0 (14-bit), the 13 raw bits after the start bit are: raw[12] = NOT scan[6], raw[11] = 0, raw[10:6] = scan[12:8], raw[5:0] = scan[5:0].
- R2: With variant code 1 (15-bit), the 14 raw bits after the start bit are scan[13:0] with bit 12 forced to 0 (scancode AND 0x2FFF).
- R3: With variant code 2 (20-bit), the 19 raw bits after the start bit are: raw[18] = NOT scan[14], raw[17] = 0, raw[16:12] = scan[20:16], raw[11:6] = scan[13:8], raw[5:0] = scan[5:0].
- R4: A frame starts, in the cycle after the accepted request, with exactly one unit of mark that stands for the start bit. The raw bits follow from the highest index down to raw[0].
- R5: Each raw bit takes two units. A 1 is space then mark, and a 0 is mark then space. Neighbouring units at the same level join into one unbroken mark or space.
- R6: In the 20-bit variant only, a four-unit space is inserted after raw[12] (the eighth bit on air counting the start bit), before raw[11].
- R7: Every frame closes with ten units of space. busy_o is high from the cycle after acceptance through the last trailer cycle, then low.
- R8: While the envelope is mark, ir_o follows a carrier of period CLK_HZ/CARRIER_HZ cycles. The carrier is high for the first half of each period, and its phase restarts at every mark onset. ir_o is low during spaces and when idle.
- R9: A request with variant code 3 while idle gives a one-cycle err_o pulse in the next cycle, and busy_o and ir_o stay low.
- R10: A request made while busy_o is high is ignored, whatever its variant code: no error pulse and no change to the frame in flight.
- R11: During and right after reset, ir_o, busy_o and err_o are low.
- R12: A request held high across the end of a frame is accepted in the first idle cycle. Exactly one idle cycle separates the two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, sampled each clock while idle |
| proto_i | input | 2 | Variant code: 0 = 14-bit, 1 = 15-bit, 2 = 20-bit, 3 = unsupported |
| scan_i | input | 21 | Scancode to be packed |
| ir_o | output | 1 | Carrier-modulated infrared drive |
| busy_o | output | 1 | Frame in progress, trailer included |
| err_o | output | 1 | One-cycle pulse for an unsupported variant code |

## Verification
The two functions that can meet in one cycle are the end of a frame (the last trailer cycle dropping busy) and the acceptance of a new request. The bench provokes this by holding the request high through a whole frame and past its end. A second collision comes from pulsing valid and invalid requests in the middle of a frame. A behavioural per-cycle model decides the outcome: the held request must start exactly one cycle after busy falls, and the mid-frame requests must leave ir_o, busy_o and err_o exactly as the model predicts for the undisturbed frame.

// File: rtl/rc5tx_pkg.sv
package rc5tx_pkg;

    // Variant codes seen on proto_i
    typedef enum logic [1:0] {
        PROTO_STD14 = 2'd0,
        PROTO_EXT15 = 2'd1,
        PROTO_X20   = 2'd2,
        PROTO_BAD   = 2'd3
    } proto_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_BITS,
        SQ_GAP,
        SQ_TRAIL
    } seq_e;

    localparam int SCAN_W      = 21;  // widest scancode
    localparam int RAW_W       = 19;  // widest raw data after the start bit
    localparam int IDX_W       = $clog2(RAW_W);
    localparam int GAP_UNITS   = 4;
    localparam int TRAIL_UNITS = 10;
    localparam int SPLIT_IDX   = 12;  // last raw bit before the extended pause
    localparam int UNITS_W     = $clog2(TRAIL_UNITS + 1);

    typedef struct packed {
        logic [RAW_W-1:0] bits;
        logic [IDX_W-1:0] top;   // index of the first raw bit on air
    } frame_t;

    function automatic logic proto_ok(proto_e p);
        return p != PROTO_BAD;
    endfunction

    function automatic frame_t pack_frame(proto_e p, logic [SCAN_W-1:0] s);
        frame_t f;
        f = '0;
        case (p)
            PROTO_STD14: begin
                f.bits[12]   = ~s[6];
                f.bits[10:6] = s[12:8];
                f.bits[5:0]  = s[5:0];
                f.top        = IDX_W'(12);
            end
            PROTO_EXT15: begin
                f.bits[13]   = s[13];
                f.bits[11:0] = s[11:0];
                f.top        = IDX_W'(13);
            end
            PROTO_X20: begin
                f.bits[18]    = ~s[14];
                f.bits[16:12] = s[20:16];
                f.bits[11:6]  = s[13:8];
                f.bits[5:0]   = s[5:0];
                f.top         = IDX_W'(18);
            end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rc5tx_unit_timer.sv
module rc5tx_unit_timer #(
    parameter int UNIT_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(UNIT_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(UNIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rc5tx_carrier.sv
module rc5tx_carrier #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic ir
);
    localparam int CW   = $clog2(DIV + 1);
    localparam int HALF = (DIV > 1) ? DIV / 2 : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !mark) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ir = mark && (cnt < CW'(HALF));

    // R8
    mark_onset_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mark) |-> ir);

endmodule

// File: rtl/rc5tx_sequencer.sv
module rc5tx_sequencer
    import rc5tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  proto_e            proto,
    input  logic [SCAN_W-1:0] scan,
    input  logic              tick,
    output logic              run,
    output logic              mark,
    output logic              busy,
    output logic              err
);
    seq_e               state;
    proto_e             proto_q;
    logic [RAW_W-1:0]   raw;
    logic [IDX_W-1:0]   idx;
    logic               half;
    logic [UNITS_W-1:0] units;
    frame_t             frame_in;
    logic               bit_now;
    logic               unused_scan_bits;

    assign unused_scan_bits = ^{scan[15], scan[7]};
    assign frame_in = pack_frame(proto, scan);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            proto_q <= PROTO_STD14;
            raw     <= '0;
            idx     <= '0;
            half    <= 1'b0;
            units   <= '0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (proto_ok(proto)) begin
                            raw     <= frame_in.bits;
                            idx     <= frame_in.top;
                            half    <= 1'b0;
                            proto_q <= proto;
                            state   <= SQ_LEAD;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                SQ_LEAD: begin
                    if (tick) state <= SQ_BITS;
                end
                SQ_BITS: begin
                    if (tick) begin
                        if (!half) begin
                            half <= 1'b1;
                        end else begin
                            half <= 1'b0;
                            if (idx == '0) begin
                                state <= SQ_TRAIL;
                                units <= '0;
                            end else if (proto_q == PROTO_X20 && idx == IDX_W'(SPLIT_IDX)) begin
                                state <= SQ_GAP;
                                units <= '0;
                            end else begin
                                idx <= idx - 1'b1;
                            end
                        end
                    end
                end
                SQ_GAP: begin
                    if (tick) begin
                        if (units == UNITS_W'(GAP_UNITS - 1)) begin
                            state <= SQ_BITS;
                            idx   <= IDX_W'(SPLIT_IDX - 1);
                        end else begin
                            units <= units + 1'b1;
                        end
                    end
                end
                SQ_TRAIL: begin
                    if (tick) begin
                        if (units == UNITS_W'(TRAIL_UNITS - 1)) state <= SQ_IDLE;
                        else                                    units <= units + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign bit_now = raw[idx];
    assign mark    = (state == SQ_LEAD) ||
                     (state == SQ_BITS && (half ? bit_now : ~bit_now));
    assign run     = (state != SQ_IDLE);
    assign busy    = run;

    // R10
    lead_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LEAD && $past(state) != SQ_LEAD) |-> $past(state) == SQ_IDLE);

    // R6
    gap_only_x20_chk: assert property (@(posedge clk) disable iff (rst)
        state == SQ_GAP |-> proto_q == PROTO_X20);

    // R7
    end_after_trail_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && $past(state) != SQ_IDLE) |-> $past(state) == SQ_TRAIL);

endmodule

// File: rtl/rc5tx_top.sv
module rc5tx_top
    import rc5tx_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int UNIT_NS    = 889_000,
    parameter int CARRIER_HZ = 36_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [1:0]  proto_i,
    input  logic [20:0] scan_i,
    output logic        ir_o,
    output logic        busy_o,
    output logic        err_o
);
    localparam longint UNIT_L   = (longint'(CLK_HZ) * longint'(UNIT_NS)) / longint'(1_000_000_000);
    localparam int     UNIT_CYC = (UNIT_L < 1) ? 1 : int'(UNIT_L);
    localparam int     CAR_DIV  = (CLK_HZ / CARRIER_HZ < 2) ? 2 : CLK_HZ / CARRIER_HZ;

    logic tick;
    logic run;
    logic mark;

    rc5tx_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    rc5tx_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .proto (proto_e'(proto_i)),
        .scan  (scan_i),
        .tick  (tick),
        .run   (run),
        .mark  (mark),
        .busy  (busy_o),
        .err   (err_o)
    );

    rc5tx_carrier #(.DIV(CAR_DIV)) u_car (
        .clk  (clk),
        .rst  (rst),
        .mark (mark),
        .ir   (ir_o)
    );

    // R9
    err_without_frame_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o);

    // R8
    ir_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ir_o |-> busy_o);

endmodule

// File: tb/rc5tx_top_tb.sv
module rc5tx_top_tb;
    localparam int CLK_HZ = 100_000_000;
    localparam int UNIT_NS = 200;
    localparam int CAR_HZ = 20_000_000;
    localparam int U      = 20;              // 100 MHz * 200 ns
    localparam int DIV    = CLK_HZ / CAR_HZ; // 5
    localparam int HALF   = DIV / 2;         // 2

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  proto = 2'd0;
    logic [20:0] scan = '0;
    logic        ir, busy, err;

    rc5tx_top #(.CLK_HZ(CLK_HZ), .UNIT_NS(UNIT_NS), .CARRIER_HZ(CAR_HZ)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .proto_i(proto), .scan_i(scan),
        .ir_o(ir), .busy_o(busy), .err_o(err)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    int    q_lvl[$];
    string q_tag[$];
    bit    active = 0;
    bit    prev_env = 0;
    int    t = 0;
    int    cc = 0;
    string ctx = "";

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Build the unit-by-unit envelope of one frame from the requirements
    function automatic void build(int p, logic [20:0] s);
        logic [19:0] d;
        int nb;
        string tg;
        d = '0;
        if (p == 0) begin        // R1
            nb = 13; tg = "R1 R5";
            for (int i = 0; i < 6; i++) d[i] = s[i];
            for (int i = 0; i < 5; i++) d[6+i] = s[8+i];
            d[12] = !s[6];
        end else if (p == 1) begin // R2
            nb = 14; tg = "R2 R5";
            for (int i = 0; i < 14; i++) d[i] = (i == 12) ? 1'b0 : s[i];
        end else begin           // R3
            nb = 19; tg = "R3 R5";
            for (int i = 0; i < 6; i++) d[i] = s[i];
            for (int i = 0; i < 6; i++) d[6+i] = s[8+i];
            for (int i = 0; i < 5; i++) d[12+i] = s[16+i];
            d[18] = !s[14];
        end
        q_lvl.delete(); q_tag.delete();
        q_lvl.push_back(1); q_tag.push_back("R4");
        for (int b = nb - 1; b >= 0; b--) begin
            q_lvl.push_back(d[b] ? 0 : 1); q_tag.push_back(tg);
            q_lvl.push_back(d[b] ? 1 : 0); q_tag.push_back(tg);
            if (p == 2 && b == 12)
                for (int g = 0; g < 4; g++) begin q_lvl.push_back(0); q_tag.push_back("R6"); end
        end
        for (int g = 0; g < 10; g++) begin q_lvl.push_back(0); q_tag.push_back("R7"); end
    endfunction

    // Per-cycle reference model: advance by the edge just passed, then compare
    always @(negedge clk) begin
        bit    was;
        bit    env;
        bit    e_err;
        bit    e_ir;
        string tg;
        if (rst) begin
            active = 0; prev_env = 0; cc = 0; t = 0;
        end else if (!done) begin
            cc = prev_env ? ((cc == DIV - 1) ? 0 : cc + 1) : 0;
            was = active;
            e_err = 0;
            if (was) begin
                t++;
                if (t == q_lvl.size() * U) active = 0;
            end else if (start) begin
                if (proto == 2'd3) e_err = 1;
                else begin build(int'(proto), scan); t = 0; active = 1; end
            end
            env  = active && (q_lvl[t / U] != 0);
            e_ir = env && (cc < HALF);
            tg   = active ? (env ? {"R8 ", q_tag[t / U]} : q_tag[t / U]) : "R7 R9";
            check(busy == active, {"R7 busy ", ctx}, busy, active);
            check(ir == e_ir, {tg, " ir ", ctx}, ir, e_ir);
            check(err == e_err, {"R9 err ", ctx}, err, e_err);
            prev_env = env;
        end
    end

    task automatic send(int p, logic [20:0] s);
        @(negedge clk); #2;
        proto = 2'(p); scan = s; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (active) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(ir == 1'b0, "R11 ir in reset", ir, 0);
        check(busy == 1'b0, "R11 busy in reset", busy, 0);
        check(err == 1'b0, "R11 err in reset", err, 0);
        #2 rst = 1'b0;
        repeat (2) @(negedge clk);

        send(0, 21'h01A55); wait_done();   // R1
        send(0, 21'h00000); wait_done();   // R1 all zero
        send(1, 21'h1FFFFF); wait_done();  // R2 masked bit
        send(1, 21'h0A5C3); wait_done();   // R2
        send(2, 21'h153A2C); wait_done();  // R3 R6
        send(2, 21'h000000); wait_done();  // R3
        send(3, 21'h012345); repeat (6) @(negedge clk); // R9

        // R10: requests in flight are dropped
        send(2, 21'h0F3F3F);
        repeat (100) @(negedge clk);
        ctx = "R10";
        send(0, 21'h1FFFFF);
        repeat (50) @(negedge clk);
        send(3, 21'h000001);
        wait_done();
        ctx = "";

        // R12: request held across the end of a frame
        ctx = "R12";
        @(negedge clk); #2;
        proto = 2'd1; scan = 21'h02C81; start = 1'b1;
        repeat (900) @(negedge clk);
        #2 start = 1'b0;
        wait_done();
        ctx = "";

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule